// File: doc/BRIEF.md
# Mixed-Width Dual-Port Memory

A 4096-bit storage array reached through two independent ports, A and B. Each port has its own clock, active-low synchronous reset, enable and write enable, and each picks its own data width from 1, 2, 4, 8 or 16 bits by parameter. Both ports address the same linear bit array, so a word written through a narrow port can be read back as part of a wider word on the other port, and the other way round. Every access is registered: a read shows up on the port's data output one clock edge after the address is presented.

Internally the array is split into two banks, one written only by port A and one written only by port B. A bit's value is the exclusive-OR of its two bank copies. Because each bank has a single writer, each bank sits in a single clock domain. When both ports write overlapping bits on the same edge of a shared clock, a guard stage drops port B's write to those bits, so port A's data is stored there. A port that reads bits the other port writes on the same edge gets the contents from before that write. Overlapping accesses on unrelated clocks give no defined result.

Top module: `mwdp_ram`

## Requirements
- R1: A word of width W at port address a occupies linear bits a*W (the word's bit 0) through a*W+W-1 (the word's bit W-1). A value written through one port is returned at the same bit positions by the other port, whatever its width.
- R2: Each port's width is one of 1, 2, 4, 8 or 16. Its address is log2(4096/W) bits wide, and every address from 0 up to the highest, 4096/W-1, is usable.
- R3: With enable high and write enable low, the data output takes the stored word at the presented address on the next rising edge of that port's clock, and not before that edge.
- R4: With enable and write enable high, the word is stored and the port's data output shows the written data after the same edge (write-first).
- R5: With enable low, a port neither writes nor changes its data output, whatever its write enable, address and data inputs carry.
- R6: While a port's reset is low, its data output is cleared to zero at each clock edge. Reset leaves the stored contents untouched.
- R7: When both ports write on the same edge of a shared clock and their words overlap, the overlapping bits take port A's data and port B's other bits take port B's data. Each port's output shows its own write data.
- R8: When one port reads bits that the other port writes on the same edge of a shared clock, the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_n_a | input | 1 | Port A synchronous reset of the output register, active low |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable (1 = write, 0 = read) |
| addr_a | input | A_AW | Port A word address |
| wdata_a | input | A_WIDTH | Port A write data |
| rdata_a | output | A_WIDTH | Port A registered data output |
| clk_b | input | 1 | Port B clock |
| rst_n_b | input | 1 | Port B synchronous reset of the output register, active low |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable (1 = write, 0 = read) |
| addr_b | input | B_AW | Port B word address |
| wdata_b | input | B_WIDTH | Port B write data |
| rdata_b | output | B_WIDTH | Port B registered data output |

## Verification
The bench builds the block with port A 2 bits wide (11-bit address) and port B 8 bits wide (9-bit address), and drives both clocks from one source. With these widths one B word spans four A words, so the tests can show the bit mapping in both directions, reach the top addresses on both ports, and make a same-edge collision in which a single A word lands inside a B word. The shared clock is what makes the collision and read-while-write cases (R7, R8) defined and checkable. Accesses on unrelated clocks are not exercised.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;

    // Default size of the shared bit array.
    localparam int unsigned MWDP_TOTAL_BITS = 4096;

    // Number of address bits a port of the given width needs.
    function automatic int unsigned mwdp_addr_bits(input int unsigned total, input int unsigned width);
        return $clog2(total / width);
    endfunction

endpackage

// File: rtl/mwdp_bank.sv
// One single-writer copy of the bit array. The stored value of a bit is
// the XOR of this bank and its mate, so a write stores data ^ mate bit.
module mwdp_bank #(
    parameter int unsigned TOTAL_BITS = 4096,
    parameter int unsigned OWN_W      = 1,
    parameter int unsigned FOR_W      = 16,
    parameter int unsigned OWN_AW     = 12,
    parameter int unsigned FOR_AW     = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [OWN_AW-1:0] own_addr,
    input  logic [OWN_W-1:0]  wr_data,
    input  logic [OWN_W-1:0]  wr_keep,
    input  logic [OWN_W-1:0]  mate_bits,
    input  logic [FOR_AW-1:0] for_addr,
    output logic [OWN_W-1:0]  own_rd,
    output logic [FOR_W-1:0]  for_rd
);
    localparam int unsigned IDXW   = $clog2(TOTAL_BITS);
    localparam int unsigned OWN_LG = $clog2(OWN_W);
    localparam int unsigned FOR_LG = $clog2(FOR_W);

    logic [TOTAL_BITS-1:0] cells;
    logic [IDXW-1:0]       own_base;
    logic [IDXW-1:0]       for_base;

    assign own_base = IDXW'(own_addr) << OWN_LG;
    assign for_base = IDXW'(for_addr) << FOR_LG;

    assign own_rd = cells[own_base +: OWN_W];
    assign for_rd = cells[for_base +: FOR_W];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < int'(OWN_W); i++) begin
                if (wr_keep[i]) begin
                    cells[own_base + IDXW'(i)] <= wr_data[i] ^ mate_bits[i];
                end
            end
        end
    end

endmodule

// File: rtl/mwdp_guard.sv
// Drops port B write bits that port A writes on the same edge.
// Meaningful only when both ports share one clock.
module mwdp_guard #(
    parameter int unsigned TOTAL_BITS = 4096,
    parameter int unsigned A_W        = 1,
    parameter int unsigned B_W        = 16,
    parameter int unsigned A_AW       = 12,
    parameter int unsigned B_AW       = 8
) (
    input  logic            a_wr,
    input  logic [A_AW-1:0] addr_a,
    input  logic [B_AW-1:0] addr_b,
    output logic [B_W-1:0]  b_keep
);
    localparam int unsigned IDXW = $clog2(TOTAL_BITS);
    localparam int unsigned A_LG = $clog2(A_W);
    localparam int unsigned B_LG = $clog2(B_W);

    logic [IDXW-1:0] b_base;
    assign b_base = IDXW'(addr_b) << B_LG;

    for (genvar g = 0; g < int'(B_W); g++) begin : g_bit
        logic [IDXW-1:0] pos;
        assign pos       = b_base + IDXW'(g);
        assign b_keep[g] = !(a_wr && ((pos >> A_LG) == IDXW'(addr_a)));
    end

endmodule

// File: rtl/mwdp_port.sv
// Registered data output of one port, write-first.
module mwdp_port #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] rd_bits,
    output logic [W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en) begin
            rdata <= we ? wdata : rd_bits;
        end
    end

endmodule

// File: rtl/mwdp_ram.sv
module mwdp_ram #(
    parameter int unsigned TOTAL_BITS = mwdp_pkg::MWDP_TOTAL_BITS,
    parameter int unsigned A_WIDTH    = 1,
    parameter int unsigned B_WIDTH    = 16,
    localparam int unsigned A_AW      = mwdp_pkg::mwdp_addr_bits(TOTAL_BITS, A_WIDTH),
    localparam int unsigned B_AW      = mwdp_pkg::mwdp_addr_bits(TOTAL_BITS, B_WIDTH)
) (
    input  logic               clk_a,
    input  logic               rst_n_a,
    input  logic               en_a,
    input  logic               we_a,
    input  logic [A_AW-1:0]    addr_a,
    input  logic [A_WIDTH-1:0] wdata_a,
    output logic [A_WIDTH-1:0] rdata_a,
    input  logic               clk_b,
    input  logic               rst_n_b,
    input  logic               en_b,
    input  logic               we_b,
    input  logic [B_AW-1:0]    addr_b,
    input  logic [B_WIDTH-1:0] wdata_b,
    output logic [B_WIDTH-1:0] rdata_b
);
    logic               a_wr;
    logic               b_wr;
    logic [A_WIDTH-1:0] a_own_rd;
    logic [B_WIDTH-1:0] a_for_rd;
    logic [B_WIDTH-1:0] b_own_rd;
    logic [A_WIDTH-1:0] b_for_rd;
    logic [B_WIDTH-1:0] b_keep;
    logic [A_WIDTH-1:0] rd_a;
    logic [B_WIDTH-1:0] rd_b;

    assign a_wr = en_a && we_a;
    assign b_wr = en_b && we_b;

    mwdp_guard #(
        .TOTAL_BITS(TOTAL_BITS), .A_W(A_WIDTH), .B_W(B_WIDTH),
        .A_AW(A_AW), .B_AW(B_AW)
    ) guard_i (
        .a_wr  (a_wr),
        .addr_a(addr_a),
        .addr_b(addr_b),
        .b_keep(b_keep)
    );

    mwdp_bank #(
        .TOTAL_BITS(TOTAL_BITS), .OWN_W(A_WIDTH), .FOR_W(B_WIDTH),
        .OWN_AW(A_AW), .FOR_AW(B_AW)
    ) bank_a_i (
        .clk      (clk_a),
        .wr_en    (a_wr),
        .own_addr (addr_a),
        .wr_data  (wdata_a),
        .wr_keep  ({A_WIDTH{1'b1}}),
        .mate_bits(b_for_rd),
        .for_addr (addr_b),
        .own_rd   (a_own_rd),
        .for_rd   (a_for_rd)
    );

    mwdp_bank #(
        .TOTAL_BITS(TOTAL_BITS), .OWN_W(B_WIDTH), .FOR_W(A_WIDTH),
        .OWN_AW(B_AW), .FOR_AW(A_AW)
    ) bank_b_i (
        .clk      (clk_b),
        .wr_en    (b_wr),
        .own_addr (addr_b),
        .wr_data  (wdata_b),
        .wr_keep  (b_keep),
        .mate_bits(a_for_rd),
        .for_addr (addr_a),
        .own_rd   (b_own_rd),
        .for_rd   (b_for_rd)
    );

    assign rd_a = a_own_rd ^ b_for_rd;
    assign rd_b = b_own_rd ^ a_for_rd;

    mwdp_port #(.W(A_WIDTH)) port_a_i (
        .clk(clk_a), .rst_n(rst_n_a), .en(en_a), .we(we_a),
        .wdata(wdata_a), .rd_bits(rd_a), .rdata(rdata_a)
    );

    mwdp_port #(.W(B_WIDTH)) port_b_i (
        .clk(clk_b), .rst_n(rst_n_b), .en(en_b), .we(we_b),
        .wdata(wdata_b), .rd_bits(rd_b), .rdata(rdata_b)
    );

endmodule

// File: rtl/mwdp_ram_chk.sv
module mwdp_ram_chk #(
    parameter int unsigned TOTAL_BITS = 4096,
    parameter int unsigned A_WIDTH    = 1,
    parameter int unsigned B_WIDTH    = 16,
    parameter int unsigned A_AW       = 12,
    parameter int unsigned B_AW       = 8
) (
    input logic               clk_a,
    input logic               rst_n_a,
    input logic               en_a,
    input logic               we_a,
    input logic [A_AW-1:0]    addr_a,
    input logic [A_WIDTH-1:0] wdata_a,
    input logic [A_WIDTH-1:0] rdata_a,
    input logic               clk_b,
    input logic               rst_n_b,
    input logic               en_b,
    input logic               we_b,
    input logic [B_AW-1:0]    addr_b,
    input logic [B_WIDTH-1:0] wdata_b,
    input logic [B_WIDTH-1:0] rdata_b
);
    AST_A_WRITE_ECHO: assert property (@(posedge clk_a) disable iff (!rst_n_a)
        (en_a && we_a) |=> (rdata_a == $past(wdata_a))); // R4
    AST_B_WRITE_ECHO: assert property (@(posedge clk_b) disable iff (!rst_n_b)
        (en_b && we_b) |=> (rdata_b == $past(wdata_b))); // R4
    AST_A_IDLE_HOLD: assert property (@(posedge clk_a) disable iff (!rst_n_a)
        !en_a |=> $stable(rdata_a)); // R5
    AST_B_IDLE_HOLD: assert property (@(posedge clk_b) disable iff (!rst_n_b)
        !en_b |=> $stable(rdata_b)); // R5
    AST_A_RESET_CLEAR: assert property (@(posedge clk_a) disable iff (!rst_n_a)
        $rose(rst_n_a) |-> (rdata_a == '0)); // R6
    AST_B_RESET_CLEAR: assert property (@(posedge clk_b) disable iff (!rst_n_b)
        $rose(rst_n_b) |-> (rdata_b == '0)); // R6

endmodule

bind mwdp_ram mwdp_ram_chk #(
    .TOTAL_BITS(TOTAL_BITS), .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH),
    .A_AW(A_AW), .B_AW(B_AW)
) chk_i (
    .clk_a(clk_a), .rst_n_a(rst_n_a), .en_a(en_a), .we_a(we_a),
    .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
    .clk_b(clk_b), .rst_n_b(rst_n_b), .en_b(en_b), .we_b(we_b),
    .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b)
);

// File: tb/mwdp_ram_tb_top.sv
module mwdp_ram_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       en_a, we_a, en_b, we_b;
    logic [10:0] addr_a;
    logic [1:0]  wdata_a, rdata_a;
    logic [8:0]  addr_b;
    logic [7:0]  wdata_b, rdata_b;

    mwdp_ram #(.TOTAL_BITS(4096), .A_WIDTH(2), .B_WIDTH(8)) dut_i (
        .clk_a(clk), .rst_n_a(rst_n), .en_a(en_a), .we_a(we_a),
        .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
        .clk_b(clk), .rst_n_b(rst_n), .en_b(en_b), .we_b(we_b),
        .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [4095:0] model = '0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        en_a = 1'b0; we_a = 1'b0; en_b = 1'b0; we_b = 1'b0;
    endtask

    task automatic a_write(input int a, input logic [1:0] d);
        en_a = 1'b1; we_a = 1'b1; addr_a = a[10:0]; wdata_a = d;
        tick();
        check("R4 port A write echo", 16'(rdata_a), 16'(d));
        model[a*2 +: 2] = d;
        idle();
    endtask

    task automatic b_write(input int a, input logic [7:0] d);
        en_b = 1'b1; we_b = 1'b1; addr_b = a[8:0]; wdata_b = d;
        tick();
        check("R4 port B write echo", 16'(rdata_b), 16'(d));
        model[a*8 +: 8] = d;
        idle();
    endtask

    task automatic a_read(input int a, input string tag);
        en_a = 1'b1; we_a = 1'b0; addr_a = a[10:0];
        tick();
        check(tag, 16'(rdata_a), 16'(model[a*2 +: 2]));
        idle();
    endtask

    task automatic b_read(input int a, input string tag);
        en_b = 1'b1; we_b = 1'b0; addr_b = a[8:0];
        tick();
        check(tag, 16'(rdata_b), 16'(model[a*8 +: 8]));
        idle();
    endtask

    task automatic t_reset_state();
        idle(); addr_a = '0; addr_b = '0; wdata_a = '0; wdata_b = '0;
        rst_n = 1'b0;
        tick(); tick();
        check("R6 port A output in reset", 16'(rdata_a), 16'h0);
        check("R6 port B output in reset", 16'(rdata_b), 16'h0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_a_to_b();
        // A words 4..7 fill B word 1: bits {7:6,5:4,3:2,1:0} = {0,3,2,1}
        a_write(4, 2'd1); a_write(5, 2'd2); a_write(6, 2'd3); a_write(7, 2'd0);
        en_b = 1'b1; we_b = 1'b0; addr_b = 9'd1;
        tick();
        check("R1 narrow write read wide", 16'(rdata_b), 16'h0039);
        idle();
        for (int i = 0; i < 4; i++) a_write(i, 2'(3 - i));
        b_read(0, "R1 B word 0 from A writes");
    endtask

    task automatic t_b_to_a();
        b_write(511, 8'hC6);
        en_a = 1'b1; we_a = 1'b0; addr_a = 11'd2044;
        tick(); check("R2 top A word 2044", 16'(rdata_a), 16'h2);
        addr_a = 11'd2045;
        tick(); check("R2 top A word 2045", 16'(rdata_a), 16'h1);
        addr_a = 11'd2047;
        tick(); check("R2 top A word 2047", 16'(rdata_a), 16'h3);
        idle();
        b_write(300, 8'h5A);
        for (int i = 1200; i < 1204; i++) a_read(i, "R1 A words from B write");
    endtask

    task automatic t_latency();
        a_read(2045, "R3 first read");
        en_a = 1'b1; we_a = 1'b0; addr_a = 11'd2047;
        #1;
        check("R3 output before edge", 16'(rdata_a), 16'h1);
        tick();
        check("R3 output after edge", 16'(rdata_a), 16'h3);
        idle();
    endtask

    task automatic t_enable_low();
        a_read(4, "R5 A setup read");
        en_a = 1'b0; we_a = 1'b1; addr_a = 11'd4; wdata_a = 2'd2;
        tick();
        check("R5 A output held", 16'(rdata_a), 16'h1);
        idle();
        a_read(4, "R5 A word unchanged");
        b_read(511, "R5 B setup read");
        en_b = 1'b0; we_b = 1'b1; addr_b = 9'd511; wdata_b = 8'h00;
        tick();
        check("R5 B output held", 16'(rdata_b), 16'h00C6);
        idle();
        b_read(511, "R5 B word unchanged");
    endtask

    task automatic t_collision();
        // A word 40 = bits 81:80 = B word 10 bits 1:0
        en_a = 1'b1; we_a = 1'b1; addr_a = 11'd40; wdata_a = 2'b01;
        en_b = 1'b1; we_b = 1'b1; addr_b = 9'd10; wdata_b = 8'hFF;
        tick();
        check("R7 A echo on collision", 16'(rdata_a), 16'h1);
        check("R7 B echo on collision", 16'(rdata_b), 16'h00FF);
        idle();
        model[80 +: 8] = 8'hFD;
        en_b = 1'b1; we_b = 1'b0; addr_b = 9'd10;
        tick();
        check("R7 merged B word", 16'(rdata_b), 16'h00FD);
        idle();
        a_read(40, "R7 A bits win");
        a_read(41, "R7 B bits outside overlap");
    endtask

    task automatic t_read_old();
        a_write(100, 2'b11);
        // B word 25 covers bits 207:200, holding A word 100
        en_a = 1'b1; we_a = 1'b0; addr_a = 11'd100;
        en_b = 1'b1; we_b = 1'b1; addr_b = 9'd25; wdata_b = 8'h00;
        tick();
        check("R8 same-edge read sees old", 16'(rdata_a), 16'h3);
        idle();
        model[200 +: 8] = 8'h00;
        a_read(100, "R8 later read sees new");
    endtask

    task automatic t_mid_reset();
        rst_n = 1'b0;
        tick();
        check("R6 A cleared mid-run", 16'(rdata_a), 16'h0);
        check("R6 B cleared mid-run", 16'(rdata_b), 16'h0);
        rst_n = 1'b1;
        tick();
        b_read(10, "R6 contents kept over reset");
    endtask

    initial begin
        t_reset_state();
        t_a_to_b();
        t_b_to_a();
        t_latency();
        t_enable_low();
        t_collision();
        t_read_old();
        t_mid_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule